// File: doc/BRIEF.md
# Weighted Round-Robin Arbiter

The block shares one downstream resource among a parameterized number of requesters. Each requester has a weight taken from a packed configuration vector. Once a requester wins, it keeps the grant for as many downstream acknowledges as its weight allows, as long as it keeps requesting. After that, the grant passes to the next requester that is eligible, in circular order. A requester whose weight is zero can never win.

The decision is held in registers. While a grant is held and `ack` is low, the outputs stay frozen. When the grant is idle, or in a cycle where `ack` is high, the block chooses the next owner for the following cycle. The choice comes from two parallel lowest-set-bit searches:

- one over the eligible requests at or above the rotating start position;
- one over all eligible requests.

The first search wins when it finds a candidate, so the order wraps from the last index back to index 0 at no cost. A parameter selects the grant encoding: one-hot, binary index or thermometer. Another parameter selects synchronous or asynchronous reset.

Top module: `wrr_arbiter`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, `valid` is 0 and `grant` is all zeros. The circular search then begins at index 0.
- R2: A requester i is eligible when `req[i]` is 1 and its weight field `weight[i*WT_BITS +: WT_BITS]` is nonzero. If `valid` is 0 and at least one requester is eligible at a rising edge, `valid` is 1 after that edge. The grant then names the lowest-indexed eligible requester at or above the start position, and otherwise the lowest-indexed eligible requester.
- R3: While `valid` is 1 and `ack` is 0, `grant` and `valid` hold their values at the next edge, whatever `req` and `weight` do.
- R4: A winner that keeps requesting with a nonzero weight W holds the grant for exactly W acknowledged cycles. When all requesters request continuously with `ack` held high, the grant counts stand in the ratio of the weights.
- R5: A requester with weight 0 is never granted. If only zero-weight requesters request, `valid` stays 0.
- R6: When a grant ends, the start position moves to the index just past the winner. The next owner is taken in the next cycle with no idle cycle, and the order wraps from index N_REQ-1 back to index 0.
- R7: If the owner's request is 0 at an acknowledged edge, the grant moves on at once, even when the owner has credit left.
- R8: If no requester is eligible at an acknowledged edge, `valid` is 0 after it. Whenever `valid` is 0, `grant` is all zeros.
- R9: With `ENC_MODE`=0 the grant is one-hot, with bit i set for owner i. With `ENC_MODE`=1 it is the binary index i. With `ENC_MODE`=2 it is a thermometer code, with bits 0 through i set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Active-high reset, synchronous or asynchronous by parameter |
| req | input | N_REQ | Request lines, one per requester |
| weight | input | N_REQ*WT_BITS | Packed weights; requester i occupies bits i*WT_BITS and up |
| ack | input | 1 | Downstream acknowledge; allows the grant to advance |
| grant | output | GW | Current owner in the selected encoding (N_REQ bits, or log2 N_REQ for binary) |
| valid | output | 1 | A grant is held |

## Verification
Every output of this block comes straight from state registers. Inputs applied before a rising edge therefore show up on `grant` and `valid` exactly one edge later: a new owner, a decremented credit, a frozen hold or an idle drop all take one edge.

The bench changes inputs on the falling edge and advances its reference model at the rising edge, using the inputs present there. It compares all three encodings on the following falling edge, so each result is sampled in the cycle it becomes due.

The ratio test counts grants over exactly sixty acknowledged cycles, starting from the first valid cycle after reset.

// File: rtl/wrr_pkg.sv
package wrr_pkg;

    localparam int ENC_ONEHOT = 0;
    localparam int ENC_BINARY = 1;
    localparam int ENC_THERMO = 2;

    // index width, at least one bit
    function automatic int idx_bits(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

    // grant port width for a given encoding
    function automatic int grant_bits(input int n, input int mode);
        return (mode == ENC_BINARY) ? idx_bits(n) : n;
    endfunction

endpackage

// File: rtl/wrr_prio_pick.sv
// Lowest-set-bit finder built on a log-depth prefix OR.
module wrr_prio_pick import wrr_pkg::*; #(
    parameter int N = 4
) (
    input  logic [N-1:0] vec,
    output logic [N-1:0] first,
    output logic         any
);
    localparam int STAGES = idx_bits(N);

    logic [N-1:0] lvl [STAGES+1];

    assign lvl[0] = vec;

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        assign lvl[s+1] = lvl[s] | (lvl[s] << (1 << s));
    end

    // lvl[STAGES][i] is the OR of vec[i:0]
    assign first = vec & ~(lvl[STAGES] << 1);
    assign any   = lvl[STAGES][N-1];
endmodule

// File: rtl/wrr_grant_enc.sv
// Converts the owner index into the selected output encoding.
module wrr_grant_enc import wrr_pkg::*; #(
    parameter int N    = 4,
    parameter int MODE = ENC_ONEHOT,
    parameter int IW   = 2,
    parameter int GW   = 4
) (
    input  logic          own,
    input  logic [IW-1:0] idx,
    output logic [GW-1:0] grant
);
    if (MODE == ENC_BINARY) begin : g_bin
        assign grant = own ? GW'(idx) : '0;
    end else if (MODE == ENC_THERMO) begin : g_therm
        always_comb begin
            for (int i = 0; i < GW; i++)
                grant[i] = own && (i <= int'(idx));
        end
    end else begin : g_onehot
        always_comb begin
            for (int i = 0; i < GW; i++)
                grant[i] = own && (i == int'(idx));
        end
    end
endmodule

// File: rtl/wrr_arbiter.sv
module wrr_arbiter import wrr_pkg::*; #(
    parameter int N_REQ     = 4,
    parameter int WT_BITS   = 3,
    parameter int ENC_MODE  = ENC_ONEHOT,
    parameter bit ASYNC_RST = 1'b0,
    localparam int IW = idx_bits(N_REQ),
    localparam int GW = grant_bits(N_REQ, ENC_MODE)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [N_REQ-1:0]         req,
    input  logic [N_REQ*WT_BITS-1:0] weight,
    input  logic                     ack,
    output logic [GW-1:0]            grant,
    output logic                     valid
);
    typedef struct packed {
        logic               own;     // a grant is held
        logic [IW-1:0]      idx;     // owner
        logic [WT_BITS-1:0] credit;  // acks left for the owner
        logic [N_REQ-1:0]   start;   // search mask: indices eligible first
    } arb_state_t;

    localparam arb_state_t RST_ST = '{own: 1'b0, idx: '0, credit: '0, start: '1};

    arb_state_t st, nx;

    logic [N_REQ-1:0]   elig;
    logic [N_REQ-1:0]   first_hi, first_all, pick;
    logic               any_hi, any_all;
    logic [IW-1:0]      pick_idx;
    logic [WT_BITS-1:0] pick_wt;
    logic [N_REQ-1:0]   after_mask;

    for (genvar i = 0; i < N_REQ; i++) begin : g_elig
        assign elig[i] = req[i] && (weight[i*WT_BITS +: WT_BITS] != '0);
    end

    wrr_prio_pick #(.N(N_REQ)) u_pick_hi (
        .vec(elig & st.start), .first(first_hi), .any(any_hi)
    );
    wrr_prio_pick #(.N(N_REQ)) u_pick_all (
        .vec(elig), .first(first_all), .any(any_all)
    );

    assign pick = any_hi ? first_hi : first_all;

    always_comb begin
        pick_idx   = '0;
        pick_wt    = '0;
        for (int i = 0; i < N_REQ; i++) begin
            if (pick[i]) begin
                pick_idx = pick_idx | IW'(i);
                pick_wt  = pick_wt | weight[i*WT_BITS +: WT_BITS];
            end
        end
        for (int i = 0; i < N_REQ; i++)
            after_mask[i] = (i > int'(pick_idx));
    end

    always_comb begin
        nx = st;
        if (!st.own || ack) begin
            if (st.own && (st.credit > WT_BITS'(1)) && elig[st.idx]) begin
                nx.credit = st.credit - WT_BITS'(1);
            end else if (any_all) begin
                nx.own    = 1'b1;
                nx.idx    = pick_idx;
                nx.credit = pick_wt;
                nx.start  = after_mask;
            end else begin
                nx.own = 1'b0;
            end
        end
    end

    if (ASYNC_RST) begin : g_arst
        always_ff @(posedge clk or posedge rst) begin
            if (rst) st <= RST_ST;
            else     st <= nx;
        end
    end else begin : g_srst
        always_ff @(posedge clk) begin
            if (rst) st <= RST_ST;
            else     st <= nx;
        end
    end

    wrr_grant_enc #(.N(N_REQ), .MODE(ENC_MODE), .IW(IW), .GW(GW)) u_enc (
        .own(st.own), .idx(st.idx), .grant(grant)
    );

    assign valid = st.own;
endmodule

// File: rtl/wrr_arbiter_chk.sv
module wrr_arbiter_chk #(
    parameter int N_REQ    = 4,
    parameter int WT_BITS  = 3,
    parameter int ENC_MODE = 0,
    parameter int GW       = 4
) (
    input logic                     clk,
    input logic                     rst,
    input logic [N_REQ-1:0]         req,
    input logic [N_REQ*WT_BITS-1:0] weight,
    input logic                     ack,
    input logic [GW-1:0]            grant,
    input logic                     valid
);
    logic any_elig;
    always_comb begin
        any_elig = 1'b0;
        for (int i = 0; i < N_REQ; i++)
            any_elig = any_elig | (req[i] && (weight[i*WT_BITS +: WT_BITS] != '0));
    end

    assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (valid && !ack) |=> (valid && $stable(grant)));

    assert_wake_R2: assert property (@(posedge clk) disable iff (rst)
        (!valid && any_elig) |=> valid);

    assert_masked_idle_R5: assert property (@(posedge clk) disable iff (rst)
        (!valid && !any_elig) |=> !valid);

    assert_drain_R8: assert property (@(posedge clk) disable iff (rst)
        (valid && ack && !any_elig) |=> !valid);

    assert_zero_grant_R8: assert property (@(posedge clk) disable iff (rst)
        !valid |-> (grant == '0));

    if (ENC_MODE == 0) begin : g_oh
        assert_onehot_R9: assert property (@(posedge clk) disable iff (rst)
            $onehot0(grant));
    end
endmodule

bind wrr_arbiter wrr_arbiter_chk #(
    .N_REQ(N_REQ), .WT_BITS(WT_BITS), .ENC_MODE(ENC_MODE), .GW(GW)
) u_chk (
    .clk(clk), .rst(rst), .req(req), .weight(weight),
    .ack(ack), .grant(grant), .valid(valid)
);

// File: tb/sim_wrr_arbiter.sv
module sim_wrr_arbiter;
    localparam int CLK_PERIOD = 10;
    localparam int N  = 4;
    localparam int W  = 3;
    localparam int BW = 2;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [N-1:0] req = '0;
    logic [N*W-1:0] weight = '0;
    logic         ack = 1'b0;
    logic [N-1:0]  g_oh, g_th;
    logic [BW-1:0] g_bin;
    logic         v_oh, v_bin, v_th;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit finished = 1'b0;

    // reference state
    bit m_own;
    int m_idx, m_cred, m_ptr;

    always #(CLK_PERIOD/2) clk = ~clk;

    wrr_arbiter #(.N_REQ(N), .WT_BITS(W), .ENC_MODE(0)) u0 (
        .clk(clk), .rst(rst), .req(req), .weight(weight), .ack(ack), .grant(g_oh), .valid(v_oh));
    wrr_arbiter #(.N_REQ(N), .WT_BITS(W), .ENC_MODE(1)) u1 (
        .clk(clk), .rst(rst), .req(req), .weight(weight), .ack(ack), .grant(g_bin), .valid(v_bin));
    wrr_arbiter #(.N_REQ(N), .WT_BITS(W), .ENC_MODE(2)) u2 (
        .clk(clk), .rst(rst), .req(req), .weight(weight), .ack(ack), .grant(g_th), .valid(v_th));

    function automatic int wt(input int i);
        return int'(weight[i*W +: W]);
    endfunction

    function automatic bit elig(input int i);
        return req[i] && (wt(i) != 0);
    endfunction

    task automatic model_edge();
        bit found;
        if (rst) begin
            m_own = 0; m_idx = 0; m_cred = 0; m_ptr = 0;
        end else if (!m_own || ack) begin
            if (m_own && m_cred > 1 && elig(m_idx)) begin
                m_cred--;
            end else begin
                found = 0;
                for (int k = 0; k < N; k++) begin
                    int j;
                    j = (m_ptr + k) % N;
                    if (!found && elig(j)) begin
                        found = 1; m_idx = j; m_cred = wt(j); m_ptr = (j + 1) % N;
                    end
                end
                m_own = found;
            end
        end
    endtask

    task automatic check_one(input string tag, input string what, input int got, input int exp);
        checks++;
        if (got != exp) begin
            failures++;
            $display("FAIL %s %s got=%0h exp=%0h", tag, what, got, exp);
        end
    endtask

    task automatic check_all(input string tag);
        int e_oh, e_bin, e_th;
        e_oh  = m_own ? (1 << m_idx) : 0;
        e_bin = m_own ? m_idx : 0;
        e_th  = m_own ? ((1 << (m_idx + 1)) - 1) : 0;
        check_one(tag, "valid", int'({v_oh, v_bin, v_th}), m_own ? 7 : 0);
        check_one(tag, "onehot", int'(g_oh), e_oh);
        check_one(tag, "binary", int'(g_bin), e_bin);
        check_one(tag, "thermo", int'(g_th), e_th);
    endtask

    task automatic step(input string tag);
        @(posedge clk);
        model_edge();
        @(negedge clk);
        check_all(tag);
    endtask

    task automatic set_w(input int w0, input int w1, input int w2, input int w3);
        weight = {W'(w3), W'(w2), W'(w1), W'(w0)};
    endtask

    task automatic do_reset();
        rst = 1'b1; req = '0; ack = 1'b0;
        step("R1");
        step("R1");
        rst = 1'b0;
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000 && !finished) begin
            finished = 1'b1;
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        int cnt [N];
        @(negedge clk);
        set_w(1, 1, 1, 1);
        do_reset();
        step("R1");                          // first cycle after reset: idle

        // R2: idle, eligible requesters 1 and 3 -> lowest from index 0
        req = 4'b1010; ack = 1'b0;
        step("R2");
        check_one("R2", "owner", int'(g_bin), 1);
        // R3: hold without ack while requests change
        req = 4'b0101;
        step("R3");
        check_one("R3", "held", int'(g_oh), 4'b0010);
        step("R3");
        // R6: ack with others eligible -> next after 1 is 2, then wrap to 0
        ack = 1'b1;
        step("R6");
        check_one("R6", "next", int'(g_bin), 2);
        step("R6");
        check_one("R6", "wrap", int'(g_bin), 0);
        // R8: nothing eligible at ack -> valid drops
        req = '0;
        step("R8");
        check_one("R8", "idle", int'({v_oh, g_oh}), 0);

        // R5: only a zero-weight requester
        set_w(1, 1, 0, 1);
        req = 4'b0100;
        step("R5");
        step("R5");
        check_one("R5", "masked", int'(v_oh), 0);
        // R5: zero-weight requester skipped in circular order
        req = 4'b0101;
        step("R5");
        step("R5");
        step("R5");

        // R7: owner drops request with credit left
        set_w(3, 1, 1, 1);
        do_reset();
        req = 4'b0011; ack = 1'b1;
        step("R7");
        step("R7");
        req = 4'b0010;
        step("R7");
        check_one("R7", "moved", int'(g_bin), 1);

        // R4: ratio with weights 1,2,3,4 over 60 acknowledged cycles
        set_w(1, 2, 3, 4);
        do_reset();
        req = 4'b1111; ack = 1'b1;
        step("R4");
        for (int i = 0; i < N; i++) cnt[i] = 0;
        for (int k = 0; k < 60; k++) begin
            if (v_bin) cnt[g_bin]++;
            step("R4");
        end
        for (int i = 0; i < N; i++) check_one("R4", "ratio", cnt[i], 6 * (i + 1));

        // R9 + R6: constrained random traffic against the model
        for (int k = 0; k < 3000; k++) begin
            if (k % 50 == 0) begin
                for (int i = 0; i < N; i++)
                    weight[i*W +: W] = ($urandom_range(0, 3) == 0) ? '0 : W'($urandom_range(1, 7));
            end
            req = N'($urandom_range(0, 15));
            ack = ($urandom_range(0, 9) < 7);
            step((k % 2 == 0) ? "R6" : "R9");
        end

        if (!finished) begin
            finished = 1'b1;
            summary();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
    end
endmodule